// File: doc/BRIEF.md
# Gated Dual-Register Gray Pointer Counter

This block is the pointer engine for one side of a first-in first-out buffer that crosses clock domains. It keeps two registers side by side: a binary count and a Gray-coded copy of it. A single incrementer computes the next binary count. That value loads the binary register and, through one XOR per bit, the Gray register. The Gray register is the pointer that is handed to the other clock domain. The lower bits of the binary register index the storage array.

The caller raises `inc` to request an advance and presents a blocking status on `blocked`. This is the full flag when the block is a write pointer and the empty flag when it is a read pointer. An advance is granted only while the status is clear, so the pointer can never overrun or underrun the buffer. A request made while the status is active is refused, and it latches a sticky error flag. Only reset clears that flag.

The error flag comes from a two-state machine. In state `ERR_CLEAN` the flag is low. The transition `refused_request` (inc and blocked both high at a clock edge) moves the machine to `ERR_LATCHED`. In that state the flag is high and the only transition is `hold`, which loops back to the same state. Reset returns the machine to `ERR_CLEAN`. From `ERR_CLEAN`, any cycle without a refused request takes the `stay_clean` transition.

Top module: `gray_ptr_counter`

## Requirements
- R1: While rst_n is low (asynchronous, active low), gray_ptr, bin_addr and err_flag are all zero.
- R2: A clock edge with inc high and blocked low advances the binary count by one. bin_addr (the low ADDR_W bits of the count) shows the new value after that edge.
- R3: A clock edge with inc high and blocked high leaves gray_ptr and bin_addr unchanged.
- R4: A clock edge with inc low leaves gray_ptr and bin_addr unchanged, whatever the value of blocked.
- R5: gray_ptr always equals c ^ (c >> 1), where c is the PTR_W-bit binary count of granted advances since reset.
- R6: Consecutive gray_ptr values differ in at most one bit position, and in exactly one after a granted advance.
- R7: After 2^PTR_W granted advances from zero, the count wraps. gray_ptr and bin_addr both read zero again, and the last step into zero also changes a single bit.
- R8: err_flag is high after the first clock edge at which inc and blocked are both high.
- R9: Once high, err_flag stays high through any later inputs, including granted advances, until rst_n goes low.
- R10: blocked high with inc low does not set err_flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock of the pointer's own domain |
| rst_n | input | 1 | Asynchronous active-low reset |
| inc | input | 1 | Request to advance the pointer |
| blocked | input | 1 | Blocking status: full for a write pointer, empty for a read pointer |
| gray_ptr | output | PTR_W | Gray-coded pointer, registered |
| bin_addr | output | ADDR_W | Storage index: low bits of the binary register |
| err_flag | output | 1 | Sticky overflow or underflow indication |

## Verification
The hardest case to reach is the wrap of the Gray pointer. The last code steps back to zero, and the most significant bit is the one that toggles. The stimulus reaches this case by issuing a full 2^PTR_W granted advances after reset, then checks for zero and for a single-bit change at that step.

Stickiness is the other hard case, because it only shows after a refusal has happened. The stimulus therefore keeps running granted advances, idle cycles and blocked-but-idle cycles after the refusal, to show that the flag holds. It then applies a reset in the middle of the run to show that reset alone clears the flag.

// File: rtl/gray_ptr_pkg.sv
package gray_ptr_pkg;

    typedef enum logic {
        ERR_CLEAN   = 1'b0,
        ERR_LATCHED = 1'b1
    } err_state_e;

endpackage

// File: rtl/gray_ptr_incr.sv
module gray_ptr_incr #(
    parameter int W = 4
) (
    input  logic [W-1:0] cur,
    input  logic         adv,
    output logic [W-1:0] nxt
);
    localparam int PAD = W - 1;

    always_comb begin
        nxt = cur + {{PAD{1'b0}}, adv};
    end
endmodule

// File: rtl/gray_ptr_enc.sv
module gray_ptr_enc #(
    parameter int W = 4
) (
    input  logic [W-1:0] bin,
    output logic [W-1:0] gray
);
    localparam int TOP = W - 1;

    assign gray[TOP] = bin[TOP];

    generate
        for (genvar i = 0; i < TOP; i++) begin : g_xor
            assign gray[i] = bin[i] ^ bin[i+1];
        end
    endgenerate
endmodule

// File: rtl/gray_ptr_err_fsm.sv
module gray_ptr_err_fsm
    import gray_ptr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic refused,
    output logic flag
);
    err_state_e state_q;
    err_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ERR_CLEAN:   state_d = refused ? ERR_LATCHED : ERR_CLEAN;
            ERR_LATCHED: state_d = ERR_LATCHED;
            default:     state_d = ERR_CLEAN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ERR_CLEAN;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        unique case (state_q)
            ERR_CLEAN:   flag = 1'b0;
            ERR_LATCHED: flag = 1'b1;
            default:     flag = 1'b0;
        endcase
    end
endmodule

// File: rtl/gray_ptr_counter.sv
module gray_ptr_counter #(
    parameter int ADDR_W = 3,
    parameter int PTR_W  = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inc,
    input  logic              blocked,
    output logic [PTR_W-1:0]  gray_ptr,
    output logic [ADDR_W-1:0] bin_addr,
    output logic              err_flag
);
    logic [PTR_W-1:0] bin_q;
    logic [PTR_W-1:0] bin_d;
    logic [PTR_W-1:0] gray_q;
    logic [PTR_W-1:0] gray_d;
    logic             grant;
    logic             refused;

    assign grant   = inc & ~blocked;
    assign refused = inc & blocked;

    gray_ptr_incr #(.W(PTR_W)) u_incr (
        .cur (bin_q),
        .adv (grant),
        .nxt (bin_d)
    );

    gray_ptr_enc #(.W(PTR_W)) u_enc (
        .bin  (bin_d),
        .gray (gray_d)
    );

    gray_ptr_err_fsm u_err (
        .clk     (clk),
        .rst_n   (rst_n),
        .refused (refused),
        .flag    (err_flag)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bin_q  <= '0;
            gray_q <= '0;
        end else begin
            bin_q  <= bin_d;
            gray_q <= gray_d;
        end
    end

    assign gray_ptr = gray_q;
    assign bin_addr = bin_q[ADDR_W-1:0];
endmodule

// File: rtl/gray_ptr_counter_chk.sv
module gray_ptr_counter_chk #(
    parameter int ADDR_W = 3,
    parameter int PTR_W  = ADDR_W + 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              inc,
    input logic              blocked,
    input logic [PTR_W-1:0]  gray_ptr,
    input logic [ADDR_W-1:0] bin_addr,
    input logic              err_flag
);
    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !blocked) |=> (bin_addr == $past(bin_addr) + 1'b1));

    p_hold_blocked_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && blocked) |=> ($stable(gray_ptr) && $stable(bin_addr)));

    p_hold_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc) |=> ($stable(gray_ptr) && $stable(bin_addr)));

    p_low_bits_match_r5: assert property (@(posedge clk) disable iff (!rst_n)
        gray_ptr[ADDR_W-2:0] == (bin_addr[ADDR_W-2:0] ^ bin_addr[ADDR_W-1:1]));

    p_one_bit_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ($countones(gray_ptr ^ $past(gray_ptr)) <= 1));

    p_err_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && blocked) |=> err_flag);

    p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |=> err_flag);

    p_no_spurious_err_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!err_flag && !(inc && blocked)) |=> !err_flag);
endmodule

bind gray_ptr_counter gray_ptr_counter_chk #(
    .ADDR_W (ADDR_W),
    .PTR_W  (PTR_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .inc      (inc),
    .blocked  (blocked),
    .gray_ptr (gray_ptr),
    .bin_addr (bin_addr),
    .err_flag (err_flag)
);

// File: tb/tb_gray_ptr_counter.sv
`timescale 1ns/1ps
module tb_gray_ptr_counter;
    localparam int ADDR_W = 3;
    localparam int PTR_W  = ADDR_W + 1;
    localparam int NCODES = 1 << PTR_W;

    typedef struct {
        logic [PTR_W-1:0] cnt;
        logic             err;
        logic             adv;
        string            tag;
    } exp_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              inc = 1'b0;
    logic              blocked = 1'b0;
    logic [PTR_W-1:0]  gray_ptr;
    logic [ADDR_W-1:0] bin_addr;
    logic              err_flag;

    int n_checks = 0;
    int n_fail   = 0;
    exp_t q[$];
    logic [PTR_W-1:0] m_cnt = '0;
    logic             m_err = 1'b0;
    logic [PTR_W-1:0] prev_gray = '0;

    always #4 clk = ~clk;

    gray_ptr_counter #(.ADDR_W(ADDR_W), .PTR_W(PTR_W)) dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .inc      (inc),
        .blocked  (blocked),
        .gray_ptr (gray_ptr),
        .bin_addr (bin_addr),
        .err_flag (err_flag)
    );

    function automatic logic [PTR_W-1:0] to_gray(input logic [PTR_W-1:0] b);
        return b ^ (b >> 1);
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    task automatic step(input logic i, input logic b, input string tag);
        exp_t e;
        @(negedge clk);
        inc = i;
        blocked = b;
        if (i && !b) m_cnt = m_cnt + 1'b1;
        if (i && b)  m_err = 1'b1;
        e.cnt = m_cnt;
        e.err = m_err;
        e.adv = i && !b;
        e.tag = tag;
        q.push_back(e);
    endtask

    task automatic drain();
        wait (q.size() == 0);
        @(negedge clk);
        inc = 1'b0;
        blocked = 1'b0;
    endtask

    // Monitor: compares each expected item against the outputs after its edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (rst_n && q.size() > 0) begin
                exp_t e;
                int   hd;
                e = q.pop_front();
                check(bin_addr == e.cnt[ADDR_W-1:0], {e.tag, " bin_addr"}, bin_addr, e.cnt[ADDR_W-1:0]);
                check(gray_ptr == to_gray(e.cnt), "R5 gray_ptr", gray_ptr, to_gray(e.cnt));
                check(err_flag == e.err, {e.tag, " err_flag"}, err_flag, e.err);
                hd = $countones(gray_ptr ^ prev_gray);
                check(hd == (e.adv ? 1 : 0), "R6 gray step distance", hd, e.adv ? 1 : 0);
                prev_gray = gray_ptr;
            end
        end
    end

    initial begin
        #(8 * 200000);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(gray_ptr == '0, "R1 reset gray_ptr", gray_ptr, 0);
        check(bin_addr == '0, "R1 reset bin_addr", bin_addr, 0);
        check(err_flag == 1'b0, "R1 reset err_flag", err_flag, 0);
        rst_n = 1'b1;

        repeat (3) step(1'b0, 1'b0, "R4 idle");
        repeat (3) step(1'b0, 1'b1, "R10 blocked idle");
        repeat (5) step(1'b1, 1'b0, "R2 advance");
        step(1'b0, 1'b0, "R4 idle");
        repeat (NCODES - 5) step(1'b1, 1'b0, "R7 advance to wrap");
        drain();
        check(gray_ptr == '0, "R7 wrap gray_ptr", gray_ptr, 0);
        check(bin_addr == '0, "R7 wrap bin_addr", bin_addr, 0);
        repeat (3) step(1'b1, 1'b0, "R2 advance after wrap");
        step(1'b1, 1'b1, "R3 R8 refused request");
        step(1'b1, 1'b1, "R3 refused again");
        repeat (4) step(1'b1, 1'b0, "R9 advance while sticky");
        repeat (2) step(1'b0, 1'b0, "R9 idle while sticky");
        step(1'b0, 1'b1, "R9 blocked idle while sticky");
        drain();
        check(err_flag == 1'b1, "R9 still set", err_flag, 1);

        rst_n = 1'b0;
        #1;
        check(err_flag == 1'b0, "R9 cleared by reset", err_flag, 0);
        check(gray_ptr == '0, "R1 mid-run reset gray_ptr", gray_ptr, 0);
        m_cnt = '0;
        m_err = 1'b0;
        prev_gray = '0;
        @(negedge clk);
        rst_n = 1'b1;
        repeat (6) step(1'b1, 1'b0, "R2 advance after reset");
        step(1'b0, 1'b1, "R10 blocked idle after reset");
        drain();

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule